// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block steers operand values around the register file of a five-stage integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it takes the instruction words held in the decode, execute, memory and writeback stages, along with a few per-stage control flags, and extracts the source and destination register numbers from fixed fields. It compares the sources of the instruction now executing with the destinations of the two older instructions. From that it drives the select lines of both ALU operand multiplexers, the branch zero-test multiplexer and the store-data multiplexer that feeds the data memory.

A load that is followed at once by an instruction that needs the loaded register cannot be served by a bypass, because the data arrives one stage too late. For that case a small controller holds the program counter and the decode register for one cycle and places a no-operation into the execute stage. The controller has two states. `ST_FLOW` is normal flow. Its transition `T_STALL` to `ST_HOLD` fires when a load-use hazard is seen. `ST_HOLD` covers the cycle after the bubble, and its transition `T_RESUME` back to `ST_FLOW` is unconditional. When no hazard is present, `ST_FLOW` simply stays where it is.

Field positions are numbered with bit 0 as the most significant bit of the 32-bit word. The first source register sits in bits 6–10, which are word bits [25:21]. The second source register sits in bits 11–15, which are word bits [20:16]. A register-register instruction writes the register named in bits 16–20 (word bits [15:11]). Immediate-format and load instructions write the register named in bits 11–15.

Top module: `fwd_unit`

## Requirements
- R1: After reset the controller is in `ST_FLOW`, so `stall_hold` and `idex_nop` are 0 until a hazard appears. A stage whose write flag is 0 causes every select to read 00.
- R2: An ALU operand select is 01 (EX/MEM) when its source field matches the EX/MEM destination, `mem_wr` is 1 and `mem_is_load` is 0.
- R3: An ALU operand select is 10 (MEM/WB) when its source matches the MEM/WB destination with `wb_wr` = 1 and no EX/MEM match applies. The MEM/WB destination may be an ALU result or loaded data.
- R4: When EX/MEM and MEM/WB both qualify for the same source, the select is 01.
- R5: A source field of 0 never yields a non-zero select.
- R6: A stage whose write flag is 0 is never a bypass source.
- R7: A stage's destination is taken from word bits [15:11] when its register-register flag is 1. Otherwise it is taken from word bits [20:16].
- R8: `zero_sel` follows the first-source bypass rules while `ex_is_branch` is 1, and is 00 otherwise.
- R9: `st_data_sel` is 10 when the instruction in MEM is a store, its data register (word bits [20:16]) is non-zero, and that register matches the MEM/WB destination with `wb_wr` = 1. Otherwise it is 00.
- R10: A load in EX whose destination (word bits [20:16], non-zero) matches the decode-stage first source raises `stall_hold` and `idex_nop` together for one cycle. A match on the decode-stage second source does the same.
- R11: When the decode-stage instruction is a store, a match on its second source (the store data) does not stall.
- R12: The stall never lasts two consecutive cycles.
- R13: A load in EX/MEM is never a source for the ALU operand or zero-test selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_instr | input | 32 | Instruction word in decode |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_instr | input | 32 | Instruction word in execute (ID/EX) |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_branch | input | 1 | Execute instruction is a conditional branch |
| mem_instr | input | 32 | Instruction word in EX/MEM |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_rr | input | 1 | EX/MEM instruction has register-register format |
| mem_is_load | input | 1 | EX/MEM instruction is a load |
| mem_is_store | input | 1 | EX/MEM instruction is a store |
| wb_instr | input | 32 | Instruction word in MEM/WB |
| wb_wr | input | 1 | MEM/WB instruction writes a register |
| wb_rr | input | 1 | MEM/WB instruction has register-register format |
| alu_a_sel | output | 2 | First ALU operand select (00 RF, 01 EX/MEM, 10 MEM/WB) |
| alu_b_sel | output | 2 | Second ALU operand select |
| zero_sel | output | 2 | Branch zero-test operand select |
| st_data_sel | output | 2 | Store-data select at memory input (00 carried, 10 MEM/WB) |
| stall_hold | output | 1 | Hold PC and IF/ID this cycle |
| idex_nop | output | 1 | Load a no-operation into ID/EX this cycle |

## Verification
All selects are combinational from the stage words, so a wrong field slice, a wrong priority or a missing register-0 guard shows on the select lines in the same cycle the inputs are applied. A controller stuck in `ST_HOLD` or missing the `T_RESUME` transition appears within one clock. It shows either as a hazard that raises no stall or as a stall that repeats on the next cycle under unchanged inputs. The sweeps place each destination in both candidate fields, with a decoy value in the other field, so that a misplaced format decode changes at least one select.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;

    // Field start positions, counted from the most significant bit (bit 0).
    localparam int POS_SRC1   = 6;
    localparam int POS_SRC2   = 11;
    localparam int POS_DST_RR = 16;

    localparam int LO_SRC1   = INSTR_W - POS_SRC1   - REG_W;
    localparam int LO_SRC2   = INSTR_W - POS_SRC2   - REG_W;
    localparam int LO_DST_RR = INSTR_W - POS_DST_RR - REG_W;

    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_EXMEM = 2'b01,
        SEL_MEMWB = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } hz_state_e;

    function automatic logic [REG_W-1:0] f_src1(input logic [INSTR_W-1:0] w);
        return w[LO_SRC1 +: REG_W];
    endfunction

    function automatic logic [REG_W-1:0] f_src2(input logic [INSTR_W-1:0] w);
        return w[LO_SRC2 +: REG_W];
    endfunction

    // Register-register formats write the third field; others the second.
    function automatic logic [REG_W-1:0] f_dst(input logic [INSTR_W-1:0] w, input logic rr);
        return rr ? w[LO_DST_RR +: REG_W] : w[LO_SRC2 +: REG_W];
    endfunction

endpackage

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic          en,
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] m_dst,
    input  logic          m_ok,
    input  logic [RW-1:0] w_dst,
    input  logic          w_ok,
    output fwd_sel_e      sel
);

    logic src_live;
    logic hit_m;
    logic hit_w;

    always_comb begin
        src_live = en && (src != '0);
        hit_m    = src_live && m_ok && (m_dst == src);
        hit_w    = src_live && w_ok && (w_dst == src);
    end

    // Younger producer takes precedence.
    always_comb begin
        sel = SEL_RF;
        if (hit_m) begin
            sel = SEL_EXMEM;
        end else if (hit_w) begin
            sel = SEL_MEMWB;
        end
    end

endmodule

// File: rtl/fwd_store_pick.sv
module fwd_store_pick
    import fwd_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic          is_store,
    input  logic [RW-1:0] data_reg,
    input  logic [RW-1:0] w_dst,
    input  logic          w_ok,
    output fwd_sel_e      sel
);

    always_comb begin
        sel = SEL_RF;
        if (is_store && (data_reg != '0) && w_ok && (w_dst == data_reg)) begin
            sel = SEL_MEMWB;
        end
    end

endmodule

// File: rtl/fwd_hazard_fsm.sv
module fwd_hazard_fsm
    import fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall_hold,
    output logic idex_nop
);

    hz_state_e state_q;
    hz_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_STALL (FLOW->HOLD on hazard), T_RESUME (HOLD->FLOW).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: state_d = hazard ? ST_HOLD : ST_FLOW;
            ST_HOLD: state_d = ST_FLOW;
            default: state_d = ST_FLOW;
        endcase
    end

    always_comb begin
        stall_hold = 1'b0;
        idex_nop   = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                stall_hold = hazard;
                idex_nop   = hazard;
            end
            ST_HOLD: begin
                stall_hold = 1'b0;
                idex_nop   = 1'b0;
            end
            default: begin
                stall_hold = 1'b0;
                idex_nop   = 1'b0;
            end
        endcase
    end

    // R12: one bubble only
    a_r12_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hold |=> !stall_hold);

    // R10: hold and bubble insertion travel together
    a_r10_hold_with_nop: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hold == idex_nop);

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int IW    = INSTR_W,
    parameter int RW    = REG_W,
    parameter int N_OPS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] id_instr,
    input  logic          id_is_store,
    input  logic [IW-1:0] ex_instr,
    input  logic          ex_is_load,
    input  logic          ex_is_branch,
    input  logic [IW-1:0] mem_instr,
    input  logic          mem_wr,
    input  logic          mem_rr,
    input  logic          mem_is_load,
    input  logic          mem_is_store,
    input  logic [IW-1:0] wb_instr,
    input  logic          wb_wr,
    input  logic          wb_rr,
    output logic [1:0]    alu_a_sel,
    output logic [1:0]    alu_b_sel,
    output logic [1:0]    zero_sel,
    output logic [1:0]    st_data_sel,
    output logic          stall_hold,
    output logic          idex_nop
);

    localparam int OP_A    = 0;
    localparam int OP_B    = 1;
    localparam int OP_ZERO = 2;

    logic [RW-1:0] ex_s1, ex_s2, id_s1, id_s2;
    logic [RW-1:0] mem_dst, mem_data, wb_dst;
    logic          mem_ok;
    logic          hazard;
    logic          unused_bits;

    logic [RW-1:0] op_src [N_OPS];
    logic          op_en  [N_OPS];
    fwd_sel_e      op_sel [N_OPS];
    fwd_sel_e      st_sel;

    always_comb begin
        ex_s1    = f_src1(ex_instr);
        ex_s2    = f_src2(ex_instr);
        id_s1    = f_src1(id_instr);
        id_s2    = f_src2(id_instr);
        mem_dst  = f_dst(mem_instr, mem_rr);
        mem_data = f_src2(mem_instr);
        wb_dst   = f_dst(wb_instr, wb_rr);
        // Load data is not ready in EX/MEM; the interlock covers that case.
        mem_ok   = mem_wr && !mem_is_load;
    end

    assign unused_bits = ^{id_instr, ex_instr, mem_instr, wb_instr};

    always_comb begin
        op_src[OP_A]    = ex_s1;
        op_en[OP_A]     = 1'b1;
        op_src[OP_B]    = ex_s2;
        op_en[OP_B]     = 1'b1;
        op_src[OP_ZERO] = ex_s1;
        op_en[OP_ZERO]  = ex_is_branch;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        fwd_src_pick #(.RW(RW)) u_pick (
            .en    (op_en[g]),
            .src   (op_src[g]),
            .m_dst (mem_dst),
            .m_ok  (mem_ok),
            .w_dst (wb_dst),
            .w_ok  (wb_wr),
            .sel   (op_sel[g])
        );
    end

    fwd_store_pick #(.RW(RW)) u_store (
        .is_store (mem_is_store),
        .data_reg (mem_data),
        .w_dst    (wb_dst),
        .w_ok     (wb_wr),
        .sel      (st_sel)
    );

    // Load in EX writes its second field; store data source is served in MEM.
    always_comb begin
        hazard = ex_is_load && (ex_s2 != '0) &&
                 ((id_s1 == ex_s2) || (!id_is_store && (id_s2 == ex_s2)));
    end

    fwd_hazard_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hazard     (hazard),
        .stall_hold (stall_hold),
        .idex_nop   (idex_nop)
    );

    assign alu_a_sel   = op_sel[OP_A];
    assign alu_b_sel   = op_sel[OP_B];
    assign zero_sel    = op_sel[OP_ZERO];
    assign st_data_sel = st_sel;

    // R5: register 0 is never bypassed
    a_r5_no_r0_a: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_a_sel != 2'b00) |-> (f_src1(ex_instr) != '0));

    // R13: a load in EX/MEM never feeds the ALU
    a_r13_no_load_src: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_a_sel == 2'b01 || alu_b_sel == 2'b01) |-> (mem_wr && !mem_is_load));

    // R8: zero-test mux idle without a branch
    a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_branch |-> (zero_sel == 2'b00));

    // R9: store data only ever comes from MEM/WB
    a_r9_store_src: assert property (@(posedge clk) disable iff (!rst_n)
        (st_data_sel != 2'b00) |-> (mem_is_store && wb_wr && st_data_sel == 2'b10));

    // R10: a stall always has a load in EX behind it
    a_r10_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hold |-> ex_is_load);

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] id_instr = '0, ex_instr = '0, mem_instr = '0, wb_instr = '0;
    logic        id_is_store = 0, ex_is_load = 0, ex_is_branch = 0;
    logic        mem_wr = 0, mem_rr = 0, mem_is_load = 0, mem_is_store = 0;
    logic        wb_wr = 0, wb_rr = 0;
    logic [1:0]  alu_a_sel, alu_b_sel, zero_sel, st_data_sel;
    logic        stall_hold, idex_nop;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    fwd_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_instr(id_instr), .id_is_store(id_is_store),
        .ex_instr(ex_instr), .ex_is_load(ex_is_load), .ex_is_branch(ex_is_branch),
        .mem_instr(mem_instr), .mem_wr(mem_wr), .mem_rr(mem_rr),
        .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
        .wb_instr(wb_instr), .wb_wr(wb_wr), .wb_rr(wb_rr),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .zero_sel(zero_sel),
        .st_data_sel(st_data_sel), .stall_hold(stall_hold), .idex_nop(idex_nop)
    );

    // Fields: [25:21] first source, [20:16] second, [15:11] third.
    function automatic logic [31:0] mkw(input int f1, input int f2, input int f3);
        return {6'd0, 5'(f1), 5'(f2), 5'(f3), 11'd0};
    endfunction

    function automatic logic [31:0] mkdst(input int d, input bit rr);
        int decoy = d ^ 1;
        return rr ? mkw(d ^ 2, decoy, d) : mkw(d ^ 2, d, decoy);
    endfunction

    function automatic int exp_sel(input bit en, input int src, input int md, input bit mok,
                                   input int wd, input bit wok);
        if (!en || src == 0) return 0;
        if (mok && md == src) return 1;
        if (wok && wd == src) return 2;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 stall low in reset", {3'b0, stall_hold}, 4'd0);
        // Hazard present during reset must not stall once released until FLOW sees it.
        @(negedge clk);
        rst_n = 1'b1;
        ex_is_load = 1; ex_instr = mkw(0, 7, 0); id_instr = mkw(7, 0, 0);
        #1;
        chk("R1 FLOW after reset stalls on hazard", {3'b0, stall_hold}, 4'd1);
        chk("R10 nop with hold", {3'b0, idex_nop}, 4'd1);
        @(negedge clk);
        ex_is_load = 0; ex_instr = '0; id_instr = '0;
        @(negedge clk);
        // R1/R6: live matches but no write flags
        ex_instr = mkw(3, 3, 0); mem_instr = mkdst(3, 0); wb_instr = mkdst(3, 0);
        #1;
        chk("R1 R6 idle selects A", {2'b0, alu_a_sel}, 4'd0);
        chk("R1 R6 idle selects B", {2'b0, alu_b_sel}, 4'd0);

        // Operand bypass sweep: R2 R3 R4 R5 R6 R7 R8 R13
        for (int s1 = 0; s1 < 4; s1++)
        for (int s2 = 0; s2 < 4; s2++)
        for (int md = 0; md < 4; md++)
        for (int wd = 0; wd < 4; wd++)
        for (int mw = 0; mw < 2; mw++)
        for (int ml = 0; ml < 2; ml++)
        for (int mr = 0; mr < 2; mr++)
        for (int ww = 0; ww < 2; ww++)
        for (int wr = 0; wr < 2; wr++)
        for (int br = 0; br < 2; br++) begin
            @(negedge clk);
            ex_instr = mkw(s1, s2, 0); ex_is_branch = br[0]; ex_is_load = 0;
            mem_instr = mkdst(md, mr[0]); mem_wr = mw[0]; mem_rr = mr[0];
            mem_is_load = ml[0]; mem_is_store = 0;
            wb_instr = mkdst(wd, wr[0]); wb_wr = ww[0]; wb_rr = wr[0];
            id_instr = '0; id_is_store = 0;
            #1;
            chk("R2 R3 R4 R5 R7 R13 alu_a", {2'b0, alu_a_sel},
                4'(exp_sel(1, s1, md, mw[0] && !ml[0], wd, ww[0])));
            chk("R2 R3 R4 R5 R6 R7 alu_b", {2'b0, alu_b_sel},
                4'(exp_sel(1, s2, md, mw[0] && !ml[0], wd, ww[0])));
            chk("R8 zero_sel", {2'b0, zero_sel},
                4'(exp_sel(br[0], s1, md, mw[0] && !ml[0], wd, ww[0])));
        end

        // Store-data sweep: R9
        for (int st = 0; st < 2; st++)
        for (int sd = 0; sd < 4; sd++)
        for (int wd = 0; wd < 4; wd++)
        for (int ww = 0; ww < 2; ww++)
        for (int wr = 0; wr < 2; wr++) begin
            @(negedge clk);
            mem_instr = mkw(sd ^ 2, sd, sd ^ 1); mem_is_store = st[0];
            mem_wr = 0; mem_is_load = 0; mem_rr = 0;
            wb_instr = mkdst(wd, wr[0]); wb_wr = ww[0]; wb_rr = wr[0];
            #1;
            chk("R9 st_data_sel", {2'b0, st_data_sel},
                (st[0] && sd != 0 && ww[0] && wd == sd) ? 4'd2 : 4'd0);
        end

        // Load-use sweep: R10 R11 R12
        mem_is_store = 0; wb_wr = 0;
        for (int ld = 0; ld < 2; ld++)
        for (int d = 0; d < 4; d++)
        for (int r1 = 0; r1 < 4; r1++)
        for (int r2 = 0; r2 < 4; r2++)
        for (int st = 0; st < 2; st++) begin
            bit e;
            @(negedge clk);
            ex_is_load = ld[0]; ex_instr = mkw(d ^ 1, d, 0);
            id_instr = mkw(r1, r2, 0); id_is_store = st[0];
            e = ld[0] && d != 0 && (r1 == d || (!st[0] && r2 == d));
            #1;
            chk("R10 R11 stall_hold", {3'b0, stall_hold}, {3'b0, e});
            chk("R10 idex_nop", {3'b0, idex_nop}, {3'b0, e});
            @(negedge clk);
            #1;
            chk("R12 no second bubble", {3'b0, stall_hold}, 4'd0);
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule